// File: doc/BRIEF.md
# Host-Mirrored Control/Status Register Bank

This block sits between a host link and a user design on a prototyping board. The host sees a flat byte-addressed space through a simple synchronous port with separate read and write strobes. A small group of core registers at the bottom of the space controls the user design's environment. One control byte chooses whether the user design receives the physical switch and button levels or values that the host has written. The same byte also gates the user design's clock enable, either continuously or one cycle at a time. Other core registers keep a live copy of the user design's LED and seven-segment digit outputs, so the host can see what the board is showing.

Above the core group there is a larger set of general-purpose design registers. They are one byte each, and the host writes them freely. All of them are presented to the user design as one flat output vector, for control or monitoring hooks. The user design advances only on cycles where the clock-enable output is high. No gated clock net is created.

Top module: `hostmirror_regbank`

## Requirements
- R1: Addresses 0x00 to 0x0F select core registers and 0x10 to 0x4F select design registers. A read of any address at or above 0x50 returns 0x00, and a write there changes no register.
- R2: Each design register holds the last byte the host wrote to it. The register at address A is presented on design_q bits [8*(A-0x10)+7 : 8*(A-0x10)].
- R3: host_rdata is updated only on a clock edge where host_rd is high, with the value the addressed register held before that edge. A write and a read to the same address in the same cycle therefore return the old value. Between reads, host_rdata holds its value.
- R4: Bit 0 of the control byte (core 0x00) selects the switch source. When it is 0, user_sw and user_btn follow phys_sw and phys_btn. When it is 1, they take the host switch byte (core 0x01) and the low bits of the host button byte (core 0x02). Both host bytes read back as written.
- R5: Bit 1 of the control byte is a run bit. While it is 1, user_clk_en is high on every cycle.
- R6: Writing the control byte with bit 2 set gives exactly one cycle of user_clk_en, on the cycle after the write edge (when the run bit is 0). Bit 2 then reads back as 0.
- R7: Core 0x03 holds the LED byte and cores 0x04 to 0x07 hold digits 0 to 3 (digit k is disp_seg[8k+7:8k]). They are sampled on every clock edge, so a read returns the value from the cycle before the read. Host writes to them are ignored.
- R8: The unused core registers 0x08 to 0x0F read as 0x00 and ignore writes.
- R9: A synchronous active-high reset clears every writable register and host_rdata to 0. After reset, the physical switches are selected and user_clk_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W (8) | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| phys_sw | input | SW_W (8) | Physical switch levels |
| phys_btn | input | BTN_W (4) | Physical button levels |
| user_sw | output | SW_W (8) | Switch levels presented to the user design |
| user_btn | output | BTN_W (4) | Button levels presented to the user design |
| user_clk_en | output | 1 | Clock enable for the user design |
| disp_led | input | 8 | LED byte driven by the user design |
| disp_seg | input | N_DIGITS*8 (32) | Seven-segment digit bytes driven by the user design |
| design_q | output | N_DESIGN*8 (512) | Flat vector of all design registers |

## Verification
The assertions check four behaviours on every cycle: that read data stays put when no read is strobed, that reads above the map give zero, and how the control byte acts on the enable and the switch source in the cycle after a control write. Other behaviours need planned scenarios in the bench, because they depend on the contents of storage. These are design register contents and their place in design_q, the read-only and reserved registers ignoring writes, the one-cycle lag of the display captures, and the old-value result of a read that collides with a write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // core register indices; the capture indices are decoded by the read path
   localparam int unsigned CIDX_CTRL    = 0;
   localparam int unsigned CIDX_HOSTSW  = 1;
   localparam int unsigned CIDX_HOSTBTN = 2;
   localparam int unsigned CIDX_LED     = 3;
   localparam int unsigned CIDX_DIG0    = 4;

   // control byte bit positions
   localparam int unsigned CB_SRC  = 0;
   localparam int unsigned CB_RUN  = 1;
   localparam int unsigned CB_STEP = 2;
endpackage

// File: rtl/hmb_core_regs.sv
module hmb_core_regs
   import regbank_pkg::*;
#(
   parameter int unsigned N_CORE   = 16,
   parameter int unsigned N_DIGITS = 4,
   parameter int unsigned SW_W     = 8,
   parameter int unsigned BTN_W    = 4,
   localparam int unsigned IDX_W   = $clog2(N_CORE)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       idx,
   input  byte_t                  wdata,
   input  logic [SW_W-1:0]        phys_sw,
   input  logic [BTN_W-1:0]       phys_btn,
   input  byte_t                  led_in,
   input  logic [N_DIGITS*8-1:0]  seg_in,
   output logic [SW_W-1:0]        user_sw,
   output logic [BTN_W-1:0]       user_btn,
   output logic                   clk_en,
   output byte_t                  rd_val
);
   logic  src_host;
   logic  run_q;
   logic  step_q;
   byte_t host_sw_q;
   byte_t host_btn_q;
   byte_t led_cap;
   byte_t dig_cap [N_DIGITS];

   logic ctrl_wr;
   assign ctrl_wr = wr_en && (idx == IDX_W'(CIDX_CTRL));

   always_ff @(posedge clk) begin
      if (rst) begin
         src_host   <= 1'b0;
         run_q      <= 1'b0;
         step_q     <= 1'b0;
         host_sw_q  <= '0;
         host_btn_q <= '0;
      end else begin
         step_q <= ctrl_wr && wdata[CB_STEP];
         if (ctrl_wr) begin
            src_host <= wdata[CB_SRC];
            run_q    <= wdata[CB_RUN];
         end
         if (wr_en && idx == IDX_W'(CIDX_HOSTSW))  host_sw_q  <= wdata;
         if (wr_en && idx == IDX_W'(CIDX_HOSTBTN)) host_btn_q <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) led_cap <= '0;
      else     led_cap <= led_in;
   end

   for (genvar k = 0; k < N_DIGITS; k++) begin : g_dig
      always_ff @(posedge clk) begin
         if (rst) dig_cap[k] <= '0;
         else     dig_cap[k] <= seg_in[k*8 +: 8];
      end
   end

   assign user_sw  = src_host ? host_sw_q[SW_W-1:0]   : phys_sw;
   assign user_btn = src_host ? host_btn_q[BTN_W-1:0] : phys_btn;
   assign clk_en   = run_q | step_q;

   always_comb begin
      rd_val = '0;
      if (idx == IDX_W'(CIDX_CTRL)) begin
         rd_val[CB_SRC]  = src_host;
         rd_val[CB_RUN]  = run_q;
         rd_val[CB_STEP] = step_q;
      end
      if (idx == IDX_W'(CIDX_HOSTSW))  rd_val = host_sw_q;
      if (idx == IDX_W'(CIDX_HOSTBTN)) rd_val = host_btn_q;
      if (idx == IDX_W'(CIDX_LED))     rd_val = led_cap;
      for (int k = 0; k < N_DIGITS; k++) begin
         if (idx == IDX_W'(CIDX_DIG0 + k)) rd_val = dig_cap[k];
      end
   end
endmodule

// File: rtl/hmb_design_regs.sv
module hmb_design_regs
   import regbank_pkg::*;
#(
   parameter int unsigned N_DESIGN = 64,
   localparam int unsigned IDX_W   = $clog2(N_DESIGN)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      idx,
   input  byte_t                 wdata,
   output byte_t                 rd_val,
   output logic [N_DESIGN*8-1:0] regs_flat
);
   byte_t store [N_DESIGN];

   for (genvar i = 0; i < N_DESIGN; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)                                 store[i] <= '0;
         else if (wr_en && idx == IDX_W'(i))      store[i] <= wdata;
      end
      assign regs_flat[i*8 +: 8] = store[i];
   end

   assign rd_val = store[idx];
endmodule

// File: rtl/hmb_read_port.sv
module hmb_read_port
   import regbank_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  rd_en,
   input  logic  core_hit,
   input  logic  design_hit,
   input  byte_t core_val,
   input  byte_t design_val,
   output byte_t rdata
);
   always_ff @(posedge clk) begin
      if (rst)        rdata <= '0;
      else if (rd_en) rdata <= core_hit   ? core_val   :
                               design_hit ? design_val : '0;
   end
endmodule

// File: rtl/hostmirror_regbank.sv
module hostmirror_regbank
   import regbank_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned N_CORE   = 16,
   parameter int unsigned N_DESIGN = 64,
   parameter int unsigned N_DIGITS = 4,
   parameter int unsigned SW_W     = 8,
   parameter int unsigned BTN_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  host_wr,
   input  logic                  host_rd,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [7:0]            host_wdata,
   output logic [7:0]            host_rdata,
   input  logic [SW_W-1:0]       phys_sw,
   input  logic [BTN_W-1:0]      phys_btn,
   output logic [SW_W-1:0]       user_sw,
   output logic [BTN_W-1:0]      user_btn,
   output logic                  user_clk_en,
   input  logic [7:0]            disp_led,
   input  logic [N_DIGITS*8-1:0] disp_seg,
   output logic [N_DESIGN*8-1:0] design_q
);
   localparam int unsigned CORE_IDX_W = $clog2(N_CORE);
   localparam int unsigned DES_IDX_W  = $clog2(N_DESIGN);
   localparam int unsigned MAP_END    = N_CORE + N_DESIGN;

   if (SW_W > BYTE_W || BTN_W > BYTE_W) begin : g_bad_width
      $error("switch and button widths must fit in one byte");
   end
   if (N_CORE < CIDX_DIG0 + N_DIGITS || (1 << CORE_IDX_W) != N_CORE) begin : g_bad_core
      $error("core group must be a power of two holding all captures");
   end
   if ((1 << DES_IDX_W) != N_DESIGN || MAP_END > (1 << ADDR_W)) begin : g_bad_map
      $error("design group must be a power of two and the map must fit the address");
   end

   logic [31:0]           addr_ext;
   logic                  core_hit;
   logic                  design_hit;
   logic [CORE_IDX_W-1:0] core_idx;
   logic [DES_IDX_W-1:0]  des_idx;
   byte_t                 core_val;
   byte_t                 des_val;

   assign addr_ext   = 32'(host_addr);
   assign core_hit   = addr_ext < 32'(N_CORE);
   assign design_hit = !core_hit && addr_ext < 32'(MAP_END);
   assign core_idx   = CORE_IDX_W'(host_addr);
   assign des_idx    = DES_IDX_W'(addr_ext - 32'(N_CORE));

   hmb_core_regs #(
      .N_CORE(N_CORE), .N_DIGITS(N_DIGITS), .SW_W(SW_W), .BTN_W(BTN_W)
   ) i_core (
      .clk(clk), .rst(rst),
      .wr_en(host_wr && core_hit), .idx(core_idx), .wdata(host_wdata),
      .phys_sw(phys_sw), .phys_btn(phys_btn),
      .led_in(disp_led), .seg_in(disp_seg),
      .user_sw(user_sw), .user_btn(user_btn), .clk_en(user_clk_en),
      .rd_val(core_val)
   );

   hmb_design_regs #(.N_DESIGN(N_DESIGN)) i_design (
      .clk(clk), .rst(rst),
      .wr_en(host_wr && design_hit), .idx(des_idx), .wdata(host_wdata),
      .rd_val(des_val), .regs_flat(design_q)
   );

   hmb_read_port i_rport (
      .clk(clk), .rst(rst), .rd_en(host_rd),
      .core_hit(core_hit), .design_hit(design_hit),
      .core_val(core_val), .design_val(des_val),
      .rdata(host_rdata)
   );
endmodule

// File: rtl/hmb_checker.sv
module hmb_checker #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned N_CORE   = 16,
   parameter int unsigned N_DESIGN = 64,
   parameter int unsigned SW_W     = 8,
   parameter int unsigned BTN_W    = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              host_wr,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_addr,
   input logic [7:0]        host_wdata,
   input logic [7:0]        host_rdata,
   input logic [SW_W-1:0]   phys_sw,
   input logic [BTN_W-1:0]  phys_btn,
   input logic [SW_W-1:0]   user_sw,
   input logic [BTN_W-1:0]  user_btn,
   input logic              user_clk_en
);
   logic ctrl_wr;
   assign ctrl_wr = host_wr && host_addr == '0;

   // R3: data holds when no read was strobed
   a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(host_rd)) |-> $stable(host_rdata));

   // R1: reads beyond the map give zero
   a_r1_oor_zero: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(host_rd) && 32'($past(host_addr)) >= 32'(N_CORE + N_DESIGN))
      |-> host_rdata == 8'h00);

   // R6: a step request yields an enable on the next cycle
   a_r6_step_pulse: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && host_wdata[2]) |=> user_clk_en);

   // R5: clearing run and step stops the enable
   a_r5_run_stop: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && host_wdata[2:1] == 2'b00) |=> !user_clk_en);

   // R4: physical source after the select bit is cleared
   a_r4_phys_source: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && !host_wdata[0]) |=> (user_sw == phys_sw && user_btn == phys_btn));

   // R9: state right after reset
   a_r9_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!user_clk_en && host_rdata == 8'h00 && user_sw == phys_sw));
endmodule

bind hostmirror_regbank hmb_checker #(
   .ADDR_W(ADDR_W), .N_CORE(N_CORE), .N_DESIGN(N_DESIGN), .SW_W(SW_W), .BTN_W(BTN_W)
) i_chk (.*);

// File: tb/test_hostmirror_regbank.sv
module test_hostmirror_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int N_DESIGN   = 64;
   localparam int N_VEC      = 12;

   // {address, write data, expected read-back}
   localparam logic [23:0] VEC [N_VEC] = '{
      {8'h10, 8'hA5, 8'hA5},   // R2 lowest design reg
      {8'h4F, 8'h3C, 8'h3C},   // R2 highest design reg
      {8'h2B, 8'h77, 8'h77},   // R2 middle
      {8'h01, 8'h5A, 8'h5A},   // R4 host switch byte
      {8'h02, 8'h0F, 8'h0F},   // R4 host button byte
      {8'h50, 8'hFF, 8'h00},   // R1 first address past the map
      {8'hFF, 8'h12, 8'h00},   // R1 top address
      {8'h08, 8'h99, 8'h00},   // R8 reserved core
      {8'h0F, 8'h44, 8'h00},   // R8 reserved core
      {8'h03, 8'hEE, 8'h81},   // R7 LED capture ignores write
      {8'h07, 8'h11, 8'hD3},   // R7 digit 3 capture ignores write
      {8'h00, 8'h00, 8'h00}    // R4 control byte cleared
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          host_wr = 1'b0;
   logic          host_rd = 1'b0;
   logic [7:0]    host_addr = '0;
   logic [7:0]    host_wdata = '0;
   logic [7:0]    host_rdata;
   logic [7:0]    phys_sw = 8'h33;
   logic [3:0]    phys_btn = 4'h6;
   logic [7:0]    user_sw;
   logic [3:0]    user_btn;
   logic          user_clk_en;
   logic [7:0]    disp_led = 8'h81;
   logic [31:0]   disp_seg = 32'hD3C2B1A0;
   logic [N_DESIGN*8-1:0] design_q;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hostmirror_regbank i_hostmirror_regbank (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .phys_sw(phys_sw), .phys_btn(phys_btn), .user_sw(user_sw), .user_btn(user_btn),
      .user_clk_en(user_clk_en), .disp_led(disp_led), .disp_seg(disp_seg),
      .design_q(design_q)
   );

   task automatic check(input string req, input logic [N_DESIGN*8-1:0] act,
                        input logic [N_DESIGN*8-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] q);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(posedge clk); #1;
      host_rd = 1'b0;
      q = host_rdata;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      logic [N_DESIGN*8-1:0] exp_dq;

      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      check("R9 rdata", 512'(host_rdata), 512'(8'h00));
      check("R9 clk_en", 512'(user_clk_en), 512'(1'b0));
      check("R9 user_sw", 512'(user_sw), 512'(8'h33));
      check("R9 design_q", design_q, '0);
      @(negedge clk); rst = 1'b0;

      for (int i = 0; i < N_VEC; i++) begin
         wr(VEC[i][23:16], VEC[i][15:8]);
         rd(VEC[i][23:16], q);
         check($sformatf("R1/R2/R7/R8 vector %0d addr %0h", i, VEC[i][23:16]),
               512'(q), 512'(VEC[i][7:0]));
      end

      // R2 placement in design_q; R1 stray writes left it untouched
      exp_dq = '0;
      exp_dq[0*8 +: 8]  = 8'hA5;
      exp_dq[27*8 +: 8] = 8'h77;
      exp_dq[63*8 +: 8] = 8'h3C;
      check("R2 design_q map", design_q, exp_dq);

      // R4 source select
      check("R4 physical sw", 512'(user_sw), 512'(8'h33));
      check("R4 physical btn", 512'(user_btn), 512'(4'h6));
      wr(8'h00, 8'h01);
      check("R4 host sw", 512'(user_sw), 512'(8'h5A));
      check("R4 host btn", 512'(user_btn), 512'(4'hF));
      wr(8'h00, 8'h00);
      check("R4 back to physical", 512'(user_sw), 512'(8'h33));

      // R5 run bit
      wr(8'h00, 8'h02);
      check("R5 run on", 512'(user_clk_en), 512'(1'b1));
      repeat (3) @(posedge clk);
      #1;
      check("R5 run held", 512'(user_clk_en), 512'(1'b1));
      wr(8'h00, 8'h00);
      check("R5 run off", 512'(user_clk_en), 512'(1'b0));

      // R6 single step
      wr(8'h00, 8'h04);
      check("R6 step high", 512'(user_clk_en), 512'(1'b1));
      @(posedge clk); #1;
      check("R6 step one cycle", 512'(user_clk_en), 512'(1'b0));
      rd(8'h00, q);
      check("R6 step bit cleared", 512'(q), 512'(8'h00));

      // R3 collision returns old value, then new value
      @(negedge clk);
      host_wr = 1'b1; host_rd = 1'b1; host_addr = 8'h10; host_wdata = 8'h66;
      @(posedge clk); #1;
      host_wr = 1'b0; host_rd = 1'b0;
      check("R3 collision old", 512'(host_rdata), 512'(8'hA5));
      rd(8'h10, q);
      check("R3 new value", 512'(q), 512'(8'h66));
      wr(8'h10, 8'h99);
      repeat (2) @(posedge clk);
      #1;
      check("R3 hold without read", 512'(host_rdata), 512'(8'h66));

      // R7 capture lag: a read in the cycle the LED changes sees the old byte
      @(negedge clk);
      disp_led = 8'h42; host_rd = 1'b1; host_addr = 8'h03;
      @(posedge clk); #1;
      host_rd = 1'b0;
      check("R7 previous cycle", 512'(host_rdata), 512'(8'h81));
      rd(8'h03, q);
      check("R7 updated", 512'(q), 512'(8'h42));
      rd(8'h04, q);
      check("R7 digit 0", 512'(q), 512'(8'hA0));

      // R9 reset mid-run
      wr(8'h00, 8'h03);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      check("R9 reset design_q", design_q, '0);
      check("R9 reset clk_en", 512'(user_clk_en), 512'(1'b0));
      check("R9 reset source", 512'(user_sw), 512'(8'h33));
      @(negedge clk); rst = 1'b0;
      rd(8'h01, q);
      check("R9 host sw cleared", 512'(q), 512'(8'h00));

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule